// File: doc/BRIEF.md
# Single-Cycle 16-bit Processor Core

A compact processor core that takes one 24-bit instruction per clock from an external instruction store and finishes it on the same edge. It holds eight equivalent 16-bit working registers and a 16-bit program counter. The program counter drives the instruction-store address directly.

The instruction set covers immediate loads, register copies, add and subtract, byte-wide port input and output, and a data-memory address latch with store and load. Control flow has an unconditional jump, four conditional branches and an eight-deep hardware return stack. A subroutine is entered by pushing an immediate return address and then jumping. It is left by popping that address into the program counter. A no-operation instruction that carries a nonzero 5-bit call code holds the core until a peripheral acknowledges the call. This lets slow helpers, such as a serial link, run without their own instructions.

Data-memory timing, peripheral servicing, instruction-store contents and program tooling are outside this block.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, all eight registers, the output ports, the memory address latch and the return-stack occupancy to zero.
- R2: Instruction word: opcode in [23:19], destination/primary register in [18:16], immediate or target in [15:0], second register in [15:13]. LDI (1) loads the immediate, MOV (2) copies the second register, and LDM (17) loads `mem_rdata` into the primary register in the same cycle.
- R3: ADD (3) and SUB (4) combine the primary and second registers, and ADDI (5) adds the immediate. All three wrap modulo 65536 and write the primary register.
- R4: IN (6) loads the input byte selected by bits [1:0] into the primary register, zero-extended. OUT (7) writes the primary register's low byte to the selected output byte and leaves the other output bytes unchanged. Output byte k sits at bits [8k+7:8k].
- R5: JMP (8) sets the program counter to the immediate. Every non-control instruction that does not stall advances the program counter by one, wrapping at 16 bits.
- R6: BRZ (9) and BNZ (10) go to the 16-bit immediate when the primary register is zero (BRZ) or nonzero (BNZ). Otherwise they advance by one.
- R7: BNE (11) and BLT (12) compare the primary register with the second register as unsigned values. When the comparison holds (not equal, or primary less than second), they go to the target in bits [12:0], zero-extended. Otherwise they advance by one.
- R8: PSHI (13) pushes the 16-bit immediate onto the return stack. RTN (14) loads the most recent entry into the program counter and removes it, giving last-in first-out order.
- R9: A push to a full stack of 8 discards the oldest entry. An RTN on an empty stack advances the program counter by one.
- R10: SETA (15) latches the primary register into `mem_addr`, which holds until the next SETA. STM (16) raises `mem_we` for that cycle and drives the primary register on `mem_wdata`.
- R11: NOP (0) with a nonzero code in bits [4:0] drives that code on `call_code` and holds the program counter while `call_ack` is low. It advances by one on the cycle `call_ack` is high. A code of zero never stalls.
- R12: Bits that an instruction does not use have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 16 | Instruction-store address (program counter) |
| rom_data | input | 24 | Instruction at `rom_addr` |
| in_ports | input | 32 | Four input bytes, byte k at [8k+7:8k] |
| out_ports | output | 32 | Four registered output bytes |
| mem_addr | output | 16 | Latched data-memory address |
| mem_wdata | output | 16 | Store data (primary register) |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 16 | Load data from data memory |
| call_code | output | 5 | Active peripheral call code, zero when idle |
| call_ack | input | 1 | Peripheral done; releases a stalled call |

## Verification
A wrong register value stays hidden until an instruction reads that register. The bench therefore copies each result into `mem_addr` with SETA and compares all 16 bits one cycle later. A corrupted stack pointer or occupancy count shows up as a wrong `rom_addr` on the first RTN that follows. The overflow and underflow sequences were chosen so that every stack entry is popped and compared. A faulty branch decision shows up on `rom_addr` at the very next edge, and the sweeps cover both signs of the top bit to catch signed comparison mistakes.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int INSTR_W = 24;
  localparam int OP_W    = 5;
  localparam int RSEL_W  = 3;
  localparam int IMM_W   = 16;
  localparam int NEAR_W  = 13;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_LDI  = 5'd1,
    OP_MOV  = 5'd2,
    OP_ADD  = 5'd3,
    OP_SUB  = 5'd4,
    OP_ADDI = 5'd5,
    OP_IN   = 5'd6,
    OP_OUT  = 5'd7,
    OP_JMP  = 5'd8,
    OP_BRZ  = 5'd9,
    OP_BNZ  = 5'd10,
    OP_BNE  = 5'd11,
    OP_BLT  = 5'd12,
    OP_PSHI = 5'd13,
    OP_RTN  = 5'd14,
    OP_SETA = 5'd15,
    OP_STM  = 5'd16,
    OP_LDM  = 5'd17
  } opcode_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [RSEL_W-1:0] ra;
    logic [IMM_W-1:0]  imm;
  } instr_t;
endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int DATA_W = 16,
  parameter int NREGS  = 8,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  asel,
  output logic [DATA_W-1:0] adata,
  input  logic [SEL_W-1:0]  bsel,
  output logic [DATA_W-1:0] bdata
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                           regs_q[g] <= '0;
      else if (we && wsel == SEL_W'(g))  regs_q[g] <= wdata;
    end
  end

  assign adata = regs_q[asel];
  assign bdata = regs_q[bsel];
endmodule

// File: rtl/cpu16_retstack.sv
module cpu16_retstack #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] top_addr,
  output logic              empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_nx, wptr_pv;
  logic [CNT_W-1:0]  cnt_q;

  assign wptr_nx  = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
  assign wptr_pv  = (wptr_q == '0) ? LAST : wptr_q - 1'b1;
  assign top_addr = slot_q[wptr_pv];
  assign empty    = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (push) slot_q[wptr_q] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (push) begin
      wptr_q <= wptr_nx;
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      wptr_q <= wptr_pv;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);                                                  // R9
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
    (push && cnt_q == FULL) |=> cnt_q == FULL);                      // R9
  AST_EMPTY_POP_NOOP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (cnt_q == '0 && $stable(wptr_q)));   // R9
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int NREGS       = 8,
  parameter int STACK_DEPTH = 8,
  parameter int NPORTS      = 4,
  parameter int PORT_W      = 8,
  parameter int CALL_W      = 5,
  localparam int DATA_W     = IMM_W,
  localparam int PC_W       = IMM_W,
  localparam int SEL_W      = $clog2(NREGS),
  localparam int PSEL_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [PC_W-1:0]          rom_addr,
  input  logic [INSTR_W-1:0]       rom_data,
  input  logic [NPORTS*PORT_W-1:0] in_ports,
  output logic [NPORTS*PORT_W-1:0] out_ports,
  output logic [DATA_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     mem_we,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [CALL_W-1:0]        call_code,
  input  logic                     call_ack
);
  instr_t             ins;
  logic [SEL_W-1:0]   rs;
  logic [PSEL_W-1:0]  psel;
  logic [CALL_W-1:0]  code;
  logic [DATA_W-1:0]  a_val, b_val, wdata;
  logic               we, push, pop, out_we, seta;
  logic [PC_W-1:0]    pc_q, pc_nx, pc_inc, near_tgt, stk_top;
  logic               stk_empty;
  logic [PORT_W-1:0]  in_byte;
  logic [DATA_W-1:0]  maddr_q;
  logic [PORT_W-1:0]  out_q [NPORTS];

  assign ins      = instr_t'(rom_data);
  assign rs       = ins.imm[IMM_W-1 -: SEL_W];
  assign psel     = ins.imm[PSEL_W-1:0];
  assign code     = ins.imm[CALL_W-1:0];
  assign pc_inc   = pc_q + 1'b1;
  assign near_tgt = PC_W'(ins.imm[NEAR_W-1:0]);
  assign in_byte  = in_ports[psel*PORT_W +: PORT_W];

  cpu16_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(we), .wsel(ins.ra[SEL_W-1:0]), .wdata(wdata),
    .asel(ins.ra[SEL_W-1:0]), .adata(a_val), .bsel(rs), .bdata(b_val)
  );

  cpu16_retstack #(.ADDR_W(PC_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(push), .push_addr(ins.imm),
    .pop(pop), .top_addr(stk_top), .empty(stk_empty)
  );

  always_comb begin
    we        = 1'b0;
    wdata     = '0;
    pc_nx     = pc_inc;
    push      = 1'b0;
    pop       = 1'b0;
    out_we    = 1'b0;
    seta      = 1'b0;
    mem_we    = 1'b0;
    call_code = '0;
    case (opcode_e'(ins.op))
      OP_NOP: if (code != '0) begin
        call_code = code;
        if (!call_ack) pc_nx = pc_q;
      end
      OP_LDI:  begin we = 1'b1; wdata = ins.imm; end
      OP_MOV:  begin we = 1'b1; wdata = b_val; end
      OP_ADD:  begin we = 1'b1; wdata = a_val + b_val; end
      OP_SUB:  begin we = 1'b1; wdata = a_val - b_val; end
      OP_ADDI: begin we = 1'b1; wdata = a_val + ins.imm; end
      OP_IN:   begin we = 1'b1; wdata = DATA_W'(in_byte); end
      OP_OUT:  out_we = 1'b1;
      OP_JMP:  pc_nx = ins.imm;
      OP_BRZ:  if (a_val == '0) pc_nx = ins.imm;
      OP_BNZ:  if (a_val != '0) pc_nx = ins.imm;
      OP_BNE:  if (a_val != b_val) pc_nx = near_tgt;
      OP_BLT:  if (a_val < b_val) pc_nx = near_tgt;
      OP_PSHI: push = 1'b1;
      OP_RTN:  begin pop = 1'b1; if (!stk_empty) pc_nx = stk_top; end
      OP_SETA: seta = 1'b1;
      OP_STM:  mem_we = 1'b1;
      OP_LDM:  begin we = 1'b1; wdata = mem_rdata; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      maddr_q <= '0;
    end else begin
      pc_q <= pc_nx;
      if (seta) maddr_q <= a_val;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)                               out_q[p] <= '0;
      else if (out_we && psel == PSEL_W'(p)) out_q[p] <= a_val[PORT_W-1:0];
    end
    assign out_ports[p*PORT_W +: PORT_W] = out_q[p];
  end

  assign rom_addr  = pc_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = a_val;

  AST_JMP_LANDS: assert property (@(posedge clk) disable iff (rst)
    (ins.op == OP_JMP) |=> rom_addr == $past(ins.imm));                // R5
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (ins.op inside {OP_LDI, OP_MOV, OP_ADD, OP_SUB, OP_ADDI, OP_IN, OP_OUT,
                    OP_SETA, OP_STM, OP_LDM})
    |=> rom_addr == $past(rom_addr) + 1'b1);                           // R5
  AST_CALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ins.op == OP_NOP && code != '0 && !call_ack) |=> $stable(rom_addr)); // R11
  AST_OUT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ins.op != OP_OUT) |=> $stable(out_ports));                        // R4
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ins.op != OP_SETA) |=> $stable(mem_addr));                        // R10
endmodule

// File: tb/sim_cpu16_core.sv
module sim_cpu16_core;
  import cpu16_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] rom_addr;
  logic [23:0] rom_data;
  logic [31:0] in_ports, out_ports;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, call_ack;
  logic [4:0]  call_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cpu16_core u0 (
    .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
    .in_ports(in_ports), .out_ports(out_ports), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .call_code(call_code), .call_ack(call_ack)
  );

  function automatic logic [23:0] mk(logic [4:0] op, logic [2:0] ra, logic [15:0] imm);
    return {op, ra, imm};
  endfunction

  function automatic logic [23:0] mk2(logic [4:0] op, logic [2:0] ra, logic [2:0] rb,
                                      logic [12:0] low);
    return {op, ra, rb, low};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [23:0] i);
    rom_data = i;
    @(posedge clk);
    #1;
  endtask

  task automatic show(input logic [2:0] r, input logic [15:0] exp, input string tag);
    exec(mk(OP_SETA, r, 16'h0));
    check({16'h0, mem_addr}, {16'h0, exp}, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [8];
    logic [15:0] p;
    logic [31:0] exp_out;
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFE, 16'hFFFF, 16'h1234};

    rst = 1'b1; rom_data = '0; call_ack = 1'b0; in_ports = 32'h807FC311; mem_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    check({16'h0, rom_addr}, 32'h0, "R1 pc");
    check(out_ports, 32'h0, "R1 out_ports");
    check({16'h0, mem_addr}, 32'h0, "R1 mem_addr");
    check({27'h0, call_code}, 32'h0, "R1 call_code");
    for (int r = 0; r < 8; r++) show(3'(r), 16'h0, "R1 register cleared");
    p = rom_addr;
    exec(mk(OP_RTN, 3'd0, 16'h0));
    check({16'h0, rom_addr}, {16'h0, p + 16'd1}, "R1 R9 stack empty after reset");

    // R2 / R12: loads, copies, ignored bits
    exec(mk(OP_LDI, 3'd2, 16'hBEEF));
    show(3'd2, 16'hBEEF, "R2 LDI");
    exec(mk2(OP_MOV, 3'd5, 3'd2, 13'h1ABC));
    show(3'd5, 16'hBEEF, "R2 R12 MOV with junk low bits");
    mem_rdata = 16'h7E81;
    exec(mk(OP_LDM, 3'd6, 16'hFFFF));
    show(3'd6, 16'h7E81, "R2 R12 LDM");

    // R3: arithmetic sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        exec(mk(OP_LDI, 3'd0, vals[i]));
        exec(mk(OP_LDI, 3'd7, vals[j]));
        exec(mk2(OP_ADD, 3'd0, 3'd7, 13'h0F0F));
        show(3'd0, vals[i] + vals[j], "R3 ADD");
        exec(mk(OP_LDI, 3'd0, vals[i]));
        exec(mk2(OP_SUB, 3'd0, 3'd7, 13'h0));
        show(3'd0, vals[i] - vals[j], "R3 SUB");
        exec(mk(OP_LDI, 3'd1, vals[i]));
        exec(mk(OP_ADDI, 3'd1, vals[j]));
        show(3'd1, vals[i] + vals[j], "R3 ADDI");
      end
    end

    // R4: port input and output
    exp_out = 32'h0;
    for (int k = 0; k < 4; k++) begin
      exec(mk(OP_IN, 3'd1, {14'h3A5C, 2'(k)}));
      show(3'd1, {8'h0, in_ports[k*8 +: 8]}, "R4 R12 IN zero-extend");
      exec(mk(OP_LDI, 3'd4, 16'hA55A + 16'(k * 16'h1111)));
      exec(mk(OP_OUT, 3'd4, {14'h2F0F, 2'(k)}));
      exp_out[k*8 +: 8] = 8'(16'hA55A + 16'(k * 16'h1111));
      check(out_ports, exp_out, "R4 OUT one byte");
    end

    // R5: jump and sequential step
    exec(mk(OP_JMP, 3'd6, 16'h1234));
    check({16'h0, rom_addr}, 32'h1234, "R5 JMP");
    exec(mk(OP_JMP, 3'd0, 16'hFFFF));
    exec(mk(OP_LDI, 3'd3, 16'h0));
    check({16'h0, rom_addr}, 32'h0, "R5 step wraps");

    // R6: zero tests
    for (int i = 0; i < 8; i++) begin
      exec(mk(OP_LDI, 3'd6, vals[i]));
      p = rom_addr;
      exec(mk(OP_BRZ, 3'd6, 16'h4000));
      check({16'h0, rom_addr}, {16'h0, (vals[i] == 16'h0) ? 16'h4000 : p + 16'd1}, "R6 BRZ");
      p = rom_addr;
      exec(mk(OP_BNZ, 3'd6, 16'hC001));
      check({16'h0, rom_addr}, {16'h0, (vals[i] != 16'h0) ? 16'hC001 : p + 16'd1}, "R6 BNZ");
    end

    // R7: unsigned two-register compares
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        exec(mk(OP_LDI, 3'd1, vals[i]));
        exec(mk(OP_LDI, 3'd2, vals[j]));
        p = rom_addr;
        exec(mk2(OP_BLT, 3'd1, 3'd2, 13'h0ABC));
        check({16'h0, rom_addr}, {16'h0, (vals[i] < vals[j]) ? 16'h0ABC : p + 16'd1}, "R7 BLT");
        p = rom_addr;
        exec(mk2(OP_BNE, 3'd1, 3'd2, 13'h1F00));
        check({16'h0, rom_addr}, {16'h0, (vals[i] != vals[j]) ? 16'h1F00 : p + 16'd1}, "R7 BNE");
      end
    end

    // R8: LIFO order
    exec(mk(OP_PSHI, 3'd0, 16'h0100));
    exec(mk(OP_PSHI, 3'd0, 16'h0200));
    exec(mk(OP_PSHI, 3'd0, 16'h0300));
    exec(mk(OP_RTN, 3'd0, 16'h0));
    check({16'h0, rom_addr}, 32'h0300, "R8 RTN first");
    exec(mk(OP_RTN, 3'd0, 16'h0));
    check({16'h0, rom_addr}, 32'h0200, "R8 RTN second");
    exec(mk(OP_RTN, 3'd0, 16'h0));
    check({16'h0, rom_addr}, 32'h0100, "R8 RTN third");
    p = rom_addr;
    exec(mk(OP_RTN, 3'd0, 16'h0));
    check({16'h0, rom_addr}, {16'h0, p + 16'd1}, "R9 RTN empty");

    // R9: overflow discards oldest
    for (int n = 0; n < 9; n++) exec(mk(OP_PSHI, 3'd0, 16'h0010 + 16'(n)));
    for (int n = 8; n >= 1; n--) begin
      exec(mk(OP_RTN, 3'd0, 16'h0));
      check({16'h0, rom_addr}, {16'h0, 16'h0010 + 16'(n)}, "R9 overflow pop");
    end
    p = rom_addr;
    exec(mk(OP_RTN, 3'd0, 16'h0));
    check({16'h0, rom_addr}, {16'h0, p + 16'd1}, "R9 oldest discarded");

    // R10: memory address latch and store strobe
    exec(mk(OP_LDI, 3'd3, 16'h0FED));
    exec(mk(OP_LDI, 3'd4, 16'h5AA5));
    exec(mk(OP_SETA, 3'd3, 16'h0));
    check({16'h0, mem_addr}, 32'h0FED, "R10 SETA");
    rom_data = mk(OP_STM, 3'd4, 16'h1234);
    #1;
    check({15'h0, mem_we, mem_wdata}, {15'h0, 1'b1, 16'h5AA5}, "R10 STM strobe and data");
    @(posedge clk); #1;
    check({16'h0, mem_addr}, 32'h0FED, "R10 address held");
    rom_data = mk(OP_LDI, 3'd4, 16'h0);
    #1;
    check({31'h0, mem_we}, 32'h0, "R10 no strobe");
    @(posedge clk); #1;

    // R11: peripheral call stall
    call_ack = 1'b0;
    rom_data = mk(OP_NOP, 3'd0, 16'h0005);
    #1;
    check({27'h0, call_code}, 32'h5, "R11 call code");
    p = rom_addr;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check({16'h0, rom_addr}, {16'h0, p}, "R11 pc held");
    call_ack = 1'b1;
    @(posedge clk); #1;
    check({16'h0, rom_addr}, {16'h0, p + 16'd1}, "R11 released");
    call_ack = 1'b0;
    rom_data = mk(OP_NOP, 3'd7, 16'hFFE0);
    #1;
    check({27'h0, call_code}, 32'h0, "R11 R12 zero code idle");
    p = rom_addr;
    @(posedge clk); #1;
    check({16'h0, rom_addr}, {16'h0, p + 16'd1}, "R11 plain NOP advances");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule